// File: doc/BRIEF.md
# Block Address Translation Array

This block maps large, naturally aligned regions of the logical address space straight onto physical memory, with no page-table walk. It keeps a small set of translation entries (four by default). Each entry is built from a pair of 32-bit configuration words. The upper word carries the logical block base, a block-length field and two mode-enable bits. The lower word carries the physical block base and a two-bit protection field. Software loads the words through a single write port that selects an entry index and one of its two words.

Every cycle on which a lookup is requested, the logical address is compared against all entries in parallel, for the privilege mode of the request. The lowest-index eligible match wins. That entry supplies the physical address and a protection verdict. On a miss the block raises a miss flag, so that a page walker outside this block can take over. One parameter chooses between the data-side variant and the instruction-side variant, which differ only in how protection is judged. All results are registered and appear one cycle after the request.

Top module: `bat_xlate_array`

## Requirements
- R1: After reset, out_valid, out_hit, out_miss, out_fault, out_paddr, out_status and out_fault_addr are all zero. No entry is eligible, so any lookup misses until an entry has been loaded.
- R2: A configuration write to either word of an entry decodes that entry again from its stored word pair, but only if the stored upper word then has bit 1 or bit 0 set. Otherwise the entry keeps the translation it decoded last.
- R3: The block-length field is upper-word bits [12:2] (11 bits). The compare mask is the bitwise inverse of ((length << 17) | 0x1FFFF). A length of 0 therefore gives a 128 KiB block, and an all-ones length gives a 256 MiB block.
- R4: Upper-word bit 1 makes an entry usable in supervisor mode (lk_user = 0), and bit 0 makes it usable in user mode (lk_user = 1). An entry whose enable bit for the current mode is clear never matches.
- R5: An eligible entry matches when (lk_addr & mask) equals (upper word & mask). The physical address is then (lower word & mask) | (lk_addr & ~mask).
- R6: When several entries match, the entry with the lowest index supplies the result.
- R7: The outputs for a lookup appear on the clock edge after it is sampled. out_valid follows lk_valid by one cycle. On a valid lookup exactly one of out_hit and out_miss is set. A miss gives out_paddr, out_fault and out_status equal to zero.
- R8: In the data variant, the protection field is lower-word bits [1:0]. A value of 0 denies every access, and a value whose bit 0 is set (01 or 11) denies writes. A denied access sets out_fault, gives out_status = 0x08000000 with bit 25 set for a write, and gives out_fault_addr = the logical address. Without a fault, out_status and out_fault_addr are zero.
- R9: In the instruction variant, only a protection field of 0 faults, and the status is exactly 0x08000000. The write flag has no effect on the outcome.
- R10: The configuration port picks the entry with cfg_idx and the word with cfg_lower (0 = upper, 1 = lower). A write changes only the selected word of the selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (2) | Entry index for the configuration write |
| cfg_lower | input | 1 | 0 selects the upper word, 1 selects the lower word |
| cfg_wdata | input | 32 | Configuration word to write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address to translate |
| lk_user | input | 1 | 1 = user (problem) mode, 0 = supervisor mode |
| lk_write | input | 1 | 1 = write access |
| out_valid | output | 1 | Registered result is valid |
| out_hit | output | 1 | Lookup matched an entry |
| out_miss | output | 1 | Lookup matched no entry |
| out_paddr | output | 32 | Translated physical address |
| out_fault | output | 1 | Protection fault on the hit entry |
| out_status | output | 32 | Fault status code |
| out_fault_addr | output | 32 | Logical address of the faulting access |

## Verification
The assertions check on every cycle that the result stage tracks the request by one cycle, that hit and miss exclude each other, that a fault only comes with a hit and always carries the 0x08000000 code with the write bit as the only variable bit, that the in-block offset passes through unchanged, and that at most one entry wins and at most one entry loads per write. Only the bench scenarios can show the actual mapping arithmetic for different block lengths, the gating by mode, the lowest-index priority between overlapping entries, and the rule that a write with both enable bits clear keeps the old translation. The same scenarios are run on a data-side instance and an instruction-side instance side by side, so that the two protection rules can be compared on identical configurations.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;

  localparam int unsigned XW      = 32;
  localparam int unsigned LEN_W   = 11;
  localparam int unsigned MIN_SH  = 17;
  localparam logic [XW-1:0] FAULT_CODE = 32'h0800_0000;
  localparam int unsigned WR_BIT  = 25;

  typedef struct packed {
    logic [1:0]    acc;
    logic [1:0]    pp;
    logic [XW-1:0] mask;
    logic [XW-1:0] bepi;
    logic [XW-1:0] phys;
  } bat_ent_t;

  // Compare mask: high bits kept, block-size bits cleared.
  function automatic logic [XW-1:0] bat_make_mask(input logic [LEN_W-1:0] len);
    logic [XW-1:0] span;
    span = ({{(XW-LEN_W){1'b0}}, len} << MIN_SH) | {{(XW-MIN_SH){1'b0}}, {MIN_SH{1'b1}}};
    return ~span;
  endfunction

  function automatic bat_ent_t bat_decode(input logic [XW-1:0] up, input logic [XW-1:0] lo);
    bat_ent_t e;
    e.mask = bat_make_mask(up[12:2]);
    e.acc  = up[1:0];
    e.pp   = lo[1:0];
    e.bepi = up & e.mask;
    e.phys = lo & e.mask;
    return e;
  endfunction

  function automatic logic [1:0] bat_mode_bits(input logic user);
    return user ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [XW-1:0] bat_phys_addr(input bat_ent_t e, input logic [XW-1:0] la);
    return e.phys | (la & ~e.mask);
  endfunction

  function automatic logic bat_pp_fault(input logic [1:0] pp, input logic wr, input logic instr);
    if (pp == 2'b00) return 1'b1;
    if (instr)       return 1'b0;
    return pp[0] & wr;
  endfunction

  function automatic logic [XW-1:0] bat_fault_status(input logic wr, input logic instr);
    logic [XW-1:0] s;
    s = FAULT_CODE;
    if (!instr && wr) s[WR_BIT] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/bat_entry_store.sv
module bat_entry_store
  import bat_xlate_pkg::*;
#(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_lower,
  input  logic [XW-1:0]    cfg_wdata,
  output bat_ent_t         ent,
  output logic             load_ev
);

  logic [XW-1:0] up_q, lo_q, up_nx, lo_nx;
  logic          sel;
  bat_ent_t      ent_q;

  assign sel = cfg_we && (cfg_idx == IDX_W'(MY_IDX));

  always_comb begin
    up_nx = up_q;
    lo_nx = lo_q;
    if (sel && !cfg_lower) up_nx = cfg_wdata;
    if (sel &&  cfg_lower) lo_nx = cfg_wdata;
  end

  // Decode only when the resulting upper word enables some mode.
  assign load_ev = sel && (up_nx[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      lo_q  <= '0;
      ent_q <= '0;
    end else begin
      if (sel) begin
        up_q <= up_nx;
        lo_q <= lo_nx;
      end
      if (load_ev) ent_q <= bat_decode(up_nx, lo_nx);
    end
  end

  assign ent = ent_q;

endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_xlate_pkg::*;
(
  input  bat_ent_t      ent,
  input  logic [XW-1:0] la,
  input  logic [1:0]    mode,
  output logic          match,
  output logic [XW-1:0] paddr
);

  logic eligible, tag_eq;

  assign eligible = (ent.acc & mode) != 2'b00;
  assign tag_eq   = (la & ent.mask) == ent.bepi;
  assign match    = eligible && tag_eq;
  assign paddr    = bat_phys_addr(ent, la);

endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel
  import bat_xlate_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  logic [N_ENT-1:0]         match_v,
  input  logic [N_ENT-1:0][XW-1:0] paddr_v,
  input  logic [N_ENT-1:0][1:0]    pp_v,
  output logic                     any_hit,
  output logic [N_ENT-1:0]         win_oh,
  output logic [XW-1:0]            win_paddr,
  output logic [1:0]               win_pp
);

  // Scan from the top so that the lowest matching index is left standing.
  always_comb begin
    any_hit   = 1'b0;
    win_oh    = '0;
    win_paddr = '0;
    win_pp    = 2'b00;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_v[i]) begin
        any_hit   = 1'b1;
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_paddr = paddr_v[i];
        win_pp    = pp_v[i];
      end
    end
  end

endmodule

// File: rtl/bat_xlate_array.sv
module bat_xlate_array
  import bat_xlate_pkg::*;
#(
  parameter int unsigned N_ENT    = 4,
  parameter bit          IS_INSTR = 1'b0,
  localparam int unsigned IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_lower,
  input  logic [31:0]      cfg_wdata,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             out_valid,
  output logic             out_hit,
  output logic             out_miss,
  output logic [31:0]      out_paddr,
  output logic             out_fault,
  output logic [31:0]      out_status,
  output logic [31:0]      out_fault_addr
);

  bat_ent_t                 ent_v [N_ENT];
  logic [N_ENT-1:0]         ent_load;
  logic [N_ENT-1:0]         match_v;
  logic [N_ENT-1:0][XW-1:0] paddr_v;
  logic [N_ENT-1:0][1:0]    pp_v;
  logic [1:0]               mode;

  logic                     any_hit;
  logic [N_ENT-1:0]         sel_onehot;
  logic [XW-1:0]            win_paddr;
  logic [1:0]               win_pp;
  logic                     prot_fault;
  logic [XW-1:0]            fault_status;

  assign mode = bat_mode_bits(lk_user);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    bat_entry_store #(.IDX_W(IDX_W), .MY_IDX(g)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_lower (cfg_lower),
      .cfg_wdata (cfg_wdata),
      .ent       (ent_v[g]),
      .load_ev   (ent_load[g])
    );

    bat_entry_match u_match (
      .ent   (ent_v[g]),
      .la    (lk_addr),
      .mode  (mode),
      .match (match_v[g]),
      .paddr (paddr_v[g])
    );

    assign pp_v[g] = ent_v[g].pp;
  end

  bat_prio_sel #(.N_ENT(N_ENT)) u_prio (
    .match_v   (match_v),
    .paddr_v   (paddr_v),
    .pp_v      (pp_v),
    .any_hit   (any_hit),
    .win_oh    (sel_onehot),
    .win_paddr (win_paddr),
    .win_pp    (win_pp)
  );

  assign prot_fault   = any_hit && bat_pp_fault(win_pp, lk_write, IS_INSTR);
  assign fault_status = prot_fault ? bat_fault_status(lk_write, IS_INSTR) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_hit        <= 1'b0;
      out_miss       <= 1'b0;
      out_paddr      <= '0;
      out_fault      <= 1'b0;
      out_status     <= '0;
      out_fault_addr <= '0;
    end else begin
      out_valid      <= lk_valid;
      out_hit        <= lk_valid && any_hit;
      out_miss       <= lk_valid && !any_hit;
      out_paddr      <= (lk_valid && any_hit) ? win_paddr : '0;
      out_fault      <= lk_valid && prot_fault;
      out_status     <= lk_valid ? fault_status : '0;
      out_fault_addr <= (lk_valid && prot_fault) ? lk_addr : '0;
    end
  end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int unsigned N_ENT    = 4,
  parameter bit          IS_INSTR = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             lk_valid,
  input logic [31:0]      lk_addr,
  input logic             out_valid,
  input logic             out_hit,
  input logic             out_miss,
  input logic [31:0]      out_paddr,
  input logic             out_fault,
  input logic [31:0]      out_status,
  input logic [31:0]      out_fault_addr,
  input logic [N_ENT-1:0] sel_onehot,
  input logic [N_ENT-1:0] ent_load
);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !out_valid);
  a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit ^ out_miss));
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && !out_miss && !out_fault));
  a_r8_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_hit);
  a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> ((out_status & ~32'h0200_0000) == 32'h0800_0000));
  a_r8_no_status_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fault |-> (out_status == 32'h0 && out_fault_addr == 32'h0));
  a_r8_fault_addr_captured: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_fault_addr == $past(lk_addr)));
  a_r5_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (out_paddr[16:0] == $past(lk_addr[16:0])));
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot));
  a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_load));
  a_r2_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_load != '0) |-> cfg_we);

  if (IS_INSTR) begin : g_instr
    a_r9_instr_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_status == 32'h0800_0000));
  end

endmodule

bind bat_xlate_array bat_xlate_chk #(.N_ENT(N_ENT), .IS_INSTR(IS_INSTR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_we         (cfg_we),
  .lk_valid       (lk_valid),
  .lk_addr        (lk_addr),
  .out_valid      (out_valid),
  .out_hit        (out_hit),
  .out_miss       (out_miss),
  .out_paddr      (out_paddr),
  .out_fault      (out_fault),
  .out_status     (out_status),
  .out_fault_addr (out_fault_addr),
  .sel_onehot     (sel_onehot),
  .ent_load       (ent_load)
);

// File: tb/bat_xlate_array_bench.sv
module bat_xlate_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_lower = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_user = 1'b0;
  logic        lk_write = 1'b0;

  logic        d_valid, d_hit, d_miss, d_fault;
  logic [31:0] d_paddr, d_status, d_faddr;
  logic        i_valid, i_hit, i_miss, i_fault;
  logic [31:0] i_paddr, i_status, i_faddr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  bat_xlate_array #(.N_ENT(4), .IS_INSTR(1'b0)) u_bat_xlate_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lower(cfg_lower), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_user(lk_user), .lk_write(lk_write),
    .out_valid(d_valid), .out_hit(d_hit), .out_miss(d_miss),
    .out_paddr(d_paddr), .out_fault(d_fault), .out_status(d_status),
    .out_fault_addr(d_faddr)
  );

  bat_xlate_array #(.N_ENT(4), .IS_INSTR(1'b1)) u_bat_xlate_array_instr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lower(cfg_lower), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_user(lk_user), .lk_write(lk_write),
    .out_valid(i_valid), .out_hit(i_hit), .out_miss(i_miss),
    .out_paddr(i_paddr), .out_fault(i_fault), .out_status(i_status),
    .out_fault_addr(i_faddr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] idx, input logic lower, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_lower = lower; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive one lookup, sample both variants one edge later.
  task automatic look(input string tag, input logic [31:0] la, input logic user, input logic wr,
                      input logic e_hit, input logic [31:0] e_pa,
                      input logic e_dflt, input logic [31:0] e_dst,
                      input logic e_iflt, input logic [31:0] e_ist);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = la; lk_user = user; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " R7 valid"}, {31'b0, d_valid}, 32'd1);
    chk({tag, " R7 hit"},   {31'b0, d_hit},   {31'b0, e_hit});
    chk({tag, " R7 miss"},  {31'b0, d_miss},  {31'b0, !e_hit});
    chk({tag, " R5 paddr"}, d_paddr, e_hit ? e_pa : 32'h0);
    chk({tag, " R8 dfault"}, {31'b0, d_fault}, {31'b0, e_dflt});
    chk({tag, " R8 dstatus"}, d_status, e_dst);
    chk({tag, " R8 faddr"}, d_faddr, e_dflt ? la : 32'h0);
    chk({tag, " R9 ihit"},  {31'b0, i_hit}, {31'b0, e_hit});
    chk({tag, " R9 ipaddr"}, i_paddr, e_hit ? e_pa : 32'h0);
    chk({tag, " R9 ifault"}, {31'b0, i_fault}, {31'b0, e_iflt});
    chk({tag, " R9 istatus"}, i_status, e_ist);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {31'b0, d_valid}, 32'd0);
    chk("R1 out_hit",   {31'b0, d_hit},   32'd0);
    chk("R1 out_paddr", d_paddr, 32'h0);
    chk("R1 out_status", d_status, 32'h0);
    look("R1 empty", 32'h1000_0000, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    @(negedge clk);
    chk("R7 idle after lookup", {31'b0, d_valid}, 32'd0);
  endtask

  task automatic t_basic_map;
    // entry0: base 0x1000_0000, length 0, supervisor only, pp=2
    cfg_wr(2'd0, 1'b1, 32'h8000_0002);
    cfg_wr(2'd0, 1'b0, 32'h1000_0002);
    look("R5 basic", 32'h1001_2345, 1'b0, 1'b0, 1'b1, 32'h8001_2345, 1'b0, 0, 1'b0, 0);
    look("R3 past 128K", 32'h1002_0000, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    look("R4 user blocked", 32'h1000_0040, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_user_block;
    // entry1: base 0x2000_0000, length 3 (512 KiB), user only, pp=2
    cfg_wr(2'd1, 1'b0, 32'h2000_000D);
    cfg_wr(2'd1, 1'b1, 32'h3000_0002);
    look("R3 512K top", 32'h2007_FFFC, 1'b1, 1'b1, 1'b1, 32'h3007_FFFC, 1'b0, 0, 1'b0, 0);
    look("R4 super blocked", 32'h2000_0010, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    look("R3 past 512K", 32'h2008_0000, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_priority;
    // entry2 overlaps entry0 with a different target
    cfg_wr(2'd2, 1'b1, 32'h5000_0002);
    cfg_wr(2'd2, 1'b0, 32'h1000_0002);
    look("R6 lowest wins", 32'h1000_0010, 1'b0, 1'b0, 1'b1, 32'h8000_0010, 1'b0, 0, 1'b0, 0);
    // entry3: 256 MiB at 0x1000_0000, both modes, pp=1
    cfg_wr(2'd3, 1'b1, 32'h6000_0001);
    cfg_wr(2'd3, 1'b0, 32'h1000_1FFF);
    look("R3 256M read", 32'h1800_0004, 1'b1, 1'b0, 1'b1, 32'h6800_0004, 1'b0, 0, 1'b0, 0);
    look("R8 pp1 write", 32'h1800_0004, 1'b0, 1'b1, 1'b1, 32'h6800_0004,
         1'b1, 32'h0A00_0000, 1'b0, 0);
    look("R6 entry0 over 3", 32'h1000_0100, 1'b0, 1'b0, 1'b1, 32'h8000_0100, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_protection;
    // lower-word write reloads entry1 with pp=0
    cfg_wr(2'd1, 1'b1, 32'h3000_0000);
    look("R8 pp0 read", 32'h2000_0040, 1'b1, 1'b0, 1'b1, 32'h3000_0040,
         1'b1, 32'h0800_0000, 1'b1, 32'h0800_0000);
    look("R9 pp0 write", 32'h2000_0044, 1'b1, 1'b1, 1'b1, 32'h3000_0044,
         1'b1, 32'h0A00_0000, 1'b1, 32'h0800_0000);
    // entry0 lower to pp=3: reads fine, data writes denied
    cfg_wr(2'd0, 1'b1, 32'h8000_0003);
    look("R8 pp3 read", 32'h1000_0200, 1'b0, 1'b0, 1'b1, 32'h8000_0200, 1'b0, 0, 1'b0, 0);
    look("R8 pp3 write", 32'h1000_0204, 1'b0, 1'b1, 1'b1, 32'h8000_0204,
         1'b1, 32'h0A00_0000, 1'b0, 0);
  endtask

  task automatic t_no_reload;
    // R2: upper word with both enables clear leaves entry0 as decoded
    cfg_wr(2'd0, 1'b0, 32'h4000_0000);
    look("R2 kept after bad upper", 32'h1000_0300, 1'b0, 1'b0, 1'b1, 32'h8000_0300, 1'b0, 0, 1'b0, 0);
    look("R2 new base ignored", 32'h4000_0000, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    // R10: lower write of entry0 now stored but not decoded; entry1 untouched
    cfg_wr(2'd0, 1'b1, 32'h9000_0002);
    look("R2 lower not decoded", 32'h1000_0300, 1'b0, 1'b0, 1'b1, 32'h8000_0300, 1'b0, 0, 1'b0, 0);
    look("R10 entry1 unchanged", 32'h2000_0080, 1'b1, 1'b0, 1'b1, 32'h3000_0080,
         1'b1, 32'h0800_0000, 1'b1, 32'h0800_0000);
    // re-enabling entry0 decodes the stored pair including the new lower word
    cfg_wr(2'd0, 1'b0, 32'h1000_0002);
    look("R2 reload uses stored lower", 32'h1000_0300, 1'b0, 1'b0, 1'b1, 32'h9000_0300, 1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_map();
    t_user_block();
    t_priority();
    t_protection();
    t_no_reload();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule